// File: doc/BRIEF.md
# Bus-Master Disk DMA Register Window

This block is the register window that software uses to program a two-channel bus-master disk DMA engine through a 16-byte I/O region. Each channel owns an 8-byte slice. The slice holds a command byte that starts the engine and selects its direction. It also holds a status byte that combines software bits, sticky event bits and a live activity bit, plus a 32-bit pointer to the descriptor table in memory. The second channel's slice sits 8 bytes above the first.

The host side is a 32-bit data path. A dword index selects one of four dwords and four byte enables select the lanes, so byte, 16-bit and 32-bit accesses all use the same port. The engine side receives run, direction, a one-cycle abort strobe and the pointer for each channel. It returns per-channel activity, interrupt and error indications. The block also drives fixed reset values for a few configuration-space fields as constant outputs.

Top module: `bm_dma_regs`

## Requirements
- R1: While rst_ni is low and after it is released, every command, status and pointer register reads as zero, and run_o, to_mem_o and abort_o are all zero. The status activity bit still mirrors act_i.
- R2: Dword index 2c addresses channel c's control dword: lane 0 is the command byte and lane 2 is the status byte. Index 2c+1 addresses channel c's pointer. A write to one channel leaves the other channel unchanged.
- R3: Lanes 1 and 3 of a control dword always read 0xFF, and writes to those lanes have no effect.
- R4: In the command byte, bit 0 is run and bit 3 is direction (1 = transfer into memory). All other command bits read as zero. run_o and to_mem_o show the written values from the clock edge that takes the write.
- R5: A command write with bit 0 = 0 while run is 1 makes abort_o high for exactly the one cycle after that edge. A command write while run is already 0 gives no abort pulse.
- R6: Status bits 6 and 5 take the written value on every status-byte write.
- R7: Status bits 2 (interrupt) and 1 (error) are cleared by writing 1 to them. Writing 0 to them leaves them unchanged.
- R8: A one-cycle pulse on irq_ev_i or err_ev_i sets status bit 2 or bit 1 respectively. If a set and a software clear arrive in the same cycle, the bit ends up set.
- R9: Status bit 0 reads the current act_i combinationally and ignores writes. Status bits 7, 4 and 3 always read zero.
- R10: Each pointer byte can be written on its own through its byte enable. Pointer bits 1:0 always read zero, and desc_ptr_o carries the stored pointer.
- R11: The configuration outputs are fixed at: command word 0x0000, status word 0x0280, base-address low byte 0x01 and programming-interface byte 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Host access valid |
| we_i | input | 1 | Host access is a write |
| word_addr_i | input | 2 | Dword index within the 16-byte region |
| be_i | input | 4 | Byte-lane enables |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the addressed dword (combinational) |
| act_i | input | 2 | Per-channel transfer active from the engine |
| irq_ev_i | input | 2 | Per-channel interrupt event pulse |
| err_ev_i | input | 2 | Per-channel error event pulse |
| run_o | output | 2 | Per-channel start/stop |
| to_mem_o | output | 2 | Per-channel direction, 1 = into memory |
| abort_o | output | 2 | Per-channel one-cycle abort strobe |
| desc_ptr_o | output | 64 | Descriptor pointers, channel 0 in bits 31:0 |
| cfg_cmd_o | output | 16 | Configuration command word reset value |
| cfg_sts_o | output | 16 | Configuration status word reset value |
| cfg_bar_lo_o | output | 8 | Bus-master base address low byte |
| cfg_progif_o | output | 8 | Programming-interface byte |

## Verification
Writes take effect at the clock edge that samples them. Reads are combinational, so a written value can be read back in the cycle that follows that edge. The bench drives each access at a falling edge and checks read data shortly before the next rising edge. abort_o is registered at the same edge as the write that clears run. The bench therefore samples it at the falling edge right after that write edge, and again one cycle later to confirm it has dropped. Event pulses and the activity mirror are checked the same way: a pulse is expected in the status byte after one edge, and act_i is expected in the status byte with no edge at all.

// File: rtl/bmr_pkg.sv
package bmr_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned NB = DW / 8;

  // control dword lane layout
  localparam int unsigned CMD_LANE = 0;
  localparam int unsigned STS_LANE = 2;
  localparam logic [7:0]  PAD_BYTE = 8'hFF;

  // command byte bits
  localparam int unsigned CMD_RUN = 0;
  localparam int unsigned CMD_DIR = 3;

  // status byte bits
  localparam int unsigned STS_ACT = 0;
  localparam int unsigned STS_ERR = 1;
  localparam int unsigned STS_IRQ = 2;
  localparam int unsigned STS_CP0 = 5;
  localparam int unsigned STS_CP1 = 6;

  // configuration reset values
  localparam logic [15:0] CFG_CMD_RST  = 16'h0000;
  localparam logic [15:0] CFG_STS_RST  = 16'h0280;
  localparam logic [7:0]  CFG_BAR_LO   = 8'h01;
  localparam logic [7:0]  CFG_PROGIF   = 8'h80;
endpackage

// File: rtl/bmr_chan.sv
module bmr_chan
  import bmr_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctl_we_i,
  input  logic          ptr_we_i,
  input  logic [NB-1:0] be_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          act_i,
  input  logic          irq_ev_i,
  input  logic          err_ev_i,
  output logic [DW-1:0] ctl_rdata_o,
  output logic [DW-1:0] ptr_rdata_o,
  output logic          run_o,
  output logic          to_mem_o,
  output logic          abort_o,
  output logic [DW-1:0] ptr_o
);
  localparam int unsigned CB = CMD_LANE * 8;
  localparam int unsigned SB = STS_LANE * 8;

  logic       run_q, dir_q, irq_q, err_q, abort_q;
  logic [1:0] cap_q;
  logic [DW-1:2] ptr_q;
  logic       cmd_wr, sts_wr;
  logic [7:0] cmd_b, sts_b, cmd_wd, sts_wd;

  assign cmd_wr = ctl_we_i & be_i[CMD_LANE];
  assign sts_wr = ctl_we_i & be_i[STS_LANE];
  assign cmd_wd = wdata_i[CB +: 8];
  assign sts_wd = wdata_i[SB +: 8];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      dir_q   <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      abort_q <= cmd_wr & run_q & ~cmd_wd[CMD_RUN];
      if (cmd_wr) begin
        run_q <= cmd_wd[CMD_RUN];
        dir_q <= cmd_wd[CMD_DIR];
      end
    end
  end

  // event set has priority over write-one-to-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q <= 2'b00;
      irq_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (sts_wr) cap_q <= {sts_wd[STS_CP1], sts_wd[STS_CP0]};
      if (irq_ev_i)                        irq_q <= 1'b1;
      else if (sts_wr && sts_wd[STS_IRQ])  irq_q <= 1'b0;
      if (err_ev_i)                        err_q <= 1'b1;
      else if (sts_wr && sts_wd[STS_ERR])  err_q <= 1'b0;
    end
  end

  for (genvar l = 0; l < NB; l++) begin : g_ptr_lane
    localparam int unsigned LO = (l == 0) ? 2 : l * 8;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  ptr_q[l*8+7:LO] <= '0;
      else if (ptr_we_i && be_i[l]) ptr_q[l*8+7:LO] <= wdata_i[l*8+7:LO];
    end
  end

  always_comb begin
    cmd_b = '0;
    cmd_b[CMD_RUN] = run_q;
    cmd_b[CMD_DIR] = dir_q;
    sts_b = '0;
    sts_b[STS_ACT] = act_i;
    sts_b[STS_ERR] = err_q;
    sts_b[STS_IRQ] = irq_q;
    sts_b[STS_CP0] = cap_q[0];
    sts_b[STS_CP1] = cap_q[1];
    ctl_rdata_o = {NB{PAD_BYTE}};
    ctl_rdata_o[CB +: 8] = cmd_b;
    ctl_rdata_o[SB +: 8] = sts_b;
  end

  assign ptr_o       = {ptr_q, 2'b00};
  assign ptr_rdata_o = ptr_o;
  assign run_o       = run_q;
  assign to_mem_o    = dir_q;
  assign abort_o     = abort_q;

  logic unused_wd;
  assign unused_wd = ^{wdata_i[1:0], cmd_wd[7:4], cmd_wd[2:1], sts_wd[7], sts_wd[4:3],
                       sts_wd[0], be_i[1], be_i[3]};

  p_abort_one_shot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_q |=> !abort_q);
  p_abort_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && !run_q) |=> !abort_q);
  p_run_follows_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr |=> (run_o == $past(cmd_wd[CMD_RUN])) && (to_mem_o == $past(cmd_wd[CMD_DIR])));
  p_irq_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ev_i |=> ctl_rdata_o[SB + STS_IRQ]);
  p_err_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_ev_i |=> ctl_rdata_o[SB + STS_ERR]);
  p_irq_w1c_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_wr && sts_wd[STS_IRQ] && !irq_ev_i) |=> !ctl_rdata_o[SB + STS_IRQ]);
  p_ptr_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ptr_we_i |=> $stable(ptr_o));
endmodule

// File: rtl/bm_dma_regs.sv
module bm_dma_regs
  import bmr_pkg::*;
#(
  parameter int unsigned NUM_CH = 2,
  localparam int unsigned CW = $clog2(NUM_CH),
  localparam int unsigned AW = CW + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [AW-1:0]      word_addr_i,
  input  logic [NB-1:0]      be_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      rdata_o,
  input  logic [NUM_CH-1:0]  act_i,
  input  logic [NUM_CH-1:0]  irq_ev_i,
  input  logic [NUM_CH-1:0]  err_ev_i,
  output logic [NUM_CH-1:0]  run_o,
  output logic [NUM_CH-1:0]  to_mem_o,
  output logic [NUM_CH-1:0]  abort_o,
  output logic [NUM_CH*DW-1:0] desc_ptr_o,
  output logic [15:0]        cfg_cmd_o,
  output logic [15:0]        cfg_sts_o,
  output logic [7:0]         cfg_bar_lo_o,
  output logic [7:0]         cfg_progif_o
);
  logic [DW-1:0] ctl_rd [NUM_CH];
  logic [DW-1:0] ptr_rd [NUM_CH];
  logic [CW-1:0] ch_sel;
  logic          is_ptr, wr;

  assign ch_sel = word_addr_i[AW-1:1];
  assign is_ptr = word_addr_i[0];
  assign wr     = req_i & we_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit = wr && (ch_sel == CW'(c));
    bmr_chan u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ctl_we_i   (hit & ~is_ptr),
      .ptr_we_i   (hit & is_ptr),
      .be_i       (be_i),
      .wdata_i    (wdata_i),
      .act_i      (act_i[c]),
      .irq_ev_i   (irq_ev_i[c]),
      .err_ev_i   (err_ev_i[c]),
      .ctl_rdata_o(ctl_rd[c]),
      .ptr_rdata_o(ptr_rd[c]),
      .run_o      (run_o[c]),
      .to_mem_o   (to_mem_o[c]),
      .abort_o    (abort_o[c]),
      .ptr_o      (desc_ptr_o[c*DW +: DW])
    );
  end

  assign rdata_o      = is_ptr ? ptr_rd[ch_sel] : ctl_rd[ch_sel];
  assign cfg_cmd_o    = CFG_CMD_RST;
  assign cfg_sts_o    = CFG_STS_RST;
  assign cfg_bar_lo_o = CFG_BAR_LO;
  assign cfg_progif_o = CFG_PROGIF;

  always_comb begin
    if (rst_ni && !is_ptr)
      p_ctl_pad_r3: assert (rdata_o[15:8] == PAD_BYTE && rdata_o[31:24] == PAD_BYTE);
  end

  p_abort_after_run_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(abort_o[0]) |-> $fell(run_o[0]));
endmodule

// File: tb/bm_dma_regs_bench.sv
`timescale 1ns/1ps
module bm_dma_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  wa = '0;
  logic [3:0]  be = '0;
  logic [31:0] wd = '0;
  logic [31:0] rd;
  logic [1:0]  act = '0, irq = '0, err = '0;
  logic [1:0]  run, to_mem, abort;
  logic [63:0] dptr;
  logic [15:0] ccmd, csts;
  logic [7:0]  cbar, cpif;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bm_dma_regs u_bm_dma_regs (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .word_addr_i(wa),
    .be_i(be), .wdata_i(wd), .rdata_o(rd), .act_i(act), .irq_ev_i(irq),
    .err_ev_i(err), .run_o(run), .to_mem_o(to_mem), .abort_o(abort),
    .desc_ptr_o(dptr), .cfg_cmd_o(ccmd), .cfg_sts_o(csts),
    .cfg_bar_lo_o(cbar), .cfg_progif_o(cpif)
  );

  // {we, addr, be, wdata, expected read}
  typedef logic [70:0] vec_t;
  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    {1'b0, 2'd0, 4'hF, 32'h0,          32'hFF00FF00},
    {1'b1, 2'd0, 4'h1, 32'h000000FF,   32'h0},
    {1'b0, 2'd0, 4'hF, 32'h0,          32'hFF00FF09},
    {1'b1, 2'd0, 4'h4, 32'h00FF0000,   32'h0},
    {1'b0, 2'd0, 4'hF, 32'h0,          32'hFF60FF09},
    {1'b1, 2'd1, 4'hF, 32'h12345677,   32'h0},
    {1'b0, 2'd1, 4'hF, 32'h0,          32'h12345674},
    {1'b1, 2'd1, 4'h2, 32'h0000AB00,   32'h0},
    {1'b0, 2'd1, 4'hF, 32'h0,          32'h1234AB74},
    {1'b1, 2'd1, 4'hC, 32'hCAFE0000,   32'h0},
    {1'b0, 2'd1, 4'hF, 32'h0,          32'hCAFEAB74},
    {1'b0, 2'd2, 4'hF, 32'h0,          32'hFF00FF00},
    {1'b0, 2'd3, 4'hF, 32'h0,          32'h0},
    {1'b1, 2'd2, 4'hF, 32'hFFFFFF08,   32'h0},
    {1'b0, 2'd2, 4'hF, 32'h0,          32'hFF60FF08},
    {1'b1, 2'd3, 4'h1, 32'h00000003,   32'h0},
    {1'b0, 2'd3, 4'hF, 32'h0,          32'h0},
    {1'b1, 2'd0, 4'h4, 32'h0,          32'h0},
    {1'b0, 2'd0, 4'hF, 32'h0,          32'hFF00FF09}
  };

  task automatic chk(input string tag, input logic [63:0] act_v, input logic [63:0] exp_v);
    n_chk++;
    if (act_v !== exp_v) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act_v, exp_v);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] b, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; wa = a; be = b; wd = d;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0; we = 1'b0; be = '0; wd = '0;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] a, input logic [31:0] e);
    @(negedge clk);
    req = 1'b1; we = 1'b0; wa = a; be = 4'hF;
    #5;
    chk(tag, {32'h0, rd}, {32'h0, e});
    req = 1'b0; be = '0;
  endtask

  task automatic pulse(input bit is_err);
    @(negedge clk);
    if (is_err) err[0] = 1'b1; else irq[0] = 1'b1;
    @(negedge clk);
    err = '0; irq = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 run/to_mem/abort", {58'h0, run, to_mem, abort}, 64'h0);
    chk("R1 desc_ptr", dptr, 64'h0);
    rd_chk("R1 ch0 ctl", 2'd0, 32'hFF00FF00);
    rd_chk("R1 ch1 ptr", 2'd3, 32'h0);
    // R11 constants
    chk("R11 cfg", {ccmd, csts, cbar, cpif, 16'h0}, {16'h0000, 16'h0280, 8'h01, 8'h80, 16'h0});

    // table: R2 map/isolation, R3 pad lanes, R4 cmd bits, R6 status rw, R10 pointer lanes
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][70]) wr(VEC[i][69:68], VEC[i][67:64], VEC[i][63:32]);
      else rd_chk($sformatf("R2/R3/R4/R6/R10 vector %0d", i), VEC[i][69:68], VEC[i][31:0]);
    end

    // R4 outputs
    chk("R4 run_o", {62'h0, run}, 64'h1);
    chk("R4 to_mem_o", {62'h0, to_mem}, 64'h3);
    // R10 pointer outputs
    chk("R10 desc_ptr_o", dptr, {32'h0, 32'hCAFEAB74});

    // R5 abort on run 1->0
    wr(2'd0, 4'h1, 32'h00000008);
    chk("R5 abort pulse", {62'h0, abort}, 64'h1);
    @(negedge clk);
    chk("R5 abort one cycle", {62'h0, abort}, 64'h0);
    chk("R5 run cleared", {62'h0, run}, 64'h0);
    wr(2'd0, 4'h1, 32'h00000000);
    chk("R5 no abort when idle", {62'h0, abort}, 64'h0);
    wr(2'd2, 4'h1, 32'h00000001);
    wr(2'd2, 4'h1, 32'h00000000);
    chk("R5 ch1 abort", {62'h0, abort}, 64'h2);

    // R8 event set
    pulse(1'b0);
    rd_chk("R8 irq set", 2'd0, 32'hFF04FF00);
    pulse(1'b1);
    rd_chk("R8 err set", 2'd0, 32'hFF06FF00);
    // R7 clear one, keep other; write zero keeps
    wr(2'd0, 4'h4, 32'h00020000);
    rd_chk("R7 err w1c", 2'd0, 32'hFF04FF00);
    wr(2'd0, 4'h4, 32'h00000000);
    rd_chk("R7 zero keeps", 2'd0, 32'hFF04FF00);
    // R8 set wins over clear
    @(negedge clk);
    irq[0] = 1'b1;
    req = 1'b1; we = 1'b1; wa = 2'd0; be = 4'h4; wd = 32'h00040000;
    @(negedge clk);
    irq = '0; req = 1'b0; we = 1'b0; be = '0; wd = '0;
    rd_chk("R8 set wins", 2'd0, 32'hFF04FF00);
    wr(2'd0, 4'h4, 32'h00040000);
    rd_chk("R7 irq w1c", 2'd0, 32'hFF00FF00);

    // R9 active mirror and reserved bits
    @(negedge clk);
    act = 2'b01;
    rd_chk("R9 act mirror", 2'd0, 32'hFF01FF00);
    wr(2'd0, 4'h4, 32'h00980000);
    rd_chk("R9 reserved zero", 2'd0, 32'hFF01FF00);
    act = 2'b00;
    rd_chk("R9 act low", 2'd0, 32'hFF00FF00);

    // R1 reset mid-run
    wr(2'd0, 4'h1, 32'h00000009);
    wr(2'd1, 4'hF, 32'hFFFFFFFF);
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    chk("R1 reset outputs", {run, to_mem, abort, dptr[57:0]}, 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
    rd_chk("R1 ch0 ctl after reset", 2'd0, 32'hFF00FF00);
    rd_chk("R1 ch0 ptr after reset", 2'd1, 32'h0);

    finish_run();
  end
endmodule